// File: doc/BRIEF.md
# Power-on Strap Mode Controller for a Clock Generator

This block sits beside a multi-output clock generator and chooses how that generator runs. Four shared pins carry configuration levels while the supply comes up. Two of them pick the host frequency family and two pick the drive-current multiplier for the differential host pairs. A plain select pin (`fhi_pin`) acts as a third selector.

A fixed number of reference cycles after power-on reset is released, the block captures all five levels in one cycle. On the next cycle it turns the shared pins around into clock drivers. After that it never samples them again, and leaving power-down does not sample them either.

The captured levels are decoded into one operating mode:
- two normal host profiles, in which the analog clock paths, outside this block, are told which frequency set to produce;
- a board-test mode, in which every output group is fed from a divided copy of the reference clock, all taken from one shared counter;
- a tristate mode, in which output enable is removed;
- a reserved state, which is flagged and forces the clock sources low.

The current-select pair is turned into a two-bit multiplier code.

Top module: `strap_mode_ctrl`

## Requirements
- R1: Straps are captured exactly once after `por_n` rises: the decoded mode leaves 0 on the (HOLD_CYC+2)-th rising clock edge after the release and not earlier. With the default HOLD_CYC=8 that is edge 10.
- R2: `strap_oe` is 0 during reset and until the capture edge, and becomes 1 one clock after the capture edge.
- R3: Changes on `fsel_strap`, `isel_strap` or `fhi_pin` after the capture edge have no effect on `mode_o` or `imult_o`.
- R4: While `pwr_dn_n` is low, `grp_tclk` and `ref_pass` are low after a two-flop synchronizer. Leaving power-down does not recapture the straps.
- R5: `fsel_strap`=00 with `fhi_pin`=0 gives `mode_o`=1 (100 MHz host profile), with `ref_pass`=1, `clk_oe`=1 and `grp_tclk`=0.
- R6: `fsel_strap`=00 with `fhi_pin`=1 gives `mode_o`=2 (133 MHz host profile), with `ref_pass`=1, `clk_oe`=1 and `grp_tclk`=0.
- R7: `fsel_strap`=11 with `fhi_pin`=0 gives `mode_o`=4 (tristate), with `clk_oe`=0, `ref_pass`=0 and `grp_tclk`=0.
- R8: `fsel_strap`=11 with `fhi_pin`=1 gives `mode_o`=3 (test), with `ref_pass`=1 and `clk_oe`=1. A 3-bit counter advances by one every reference clock. `grp_tclk` bits are fed from counter bits as follows: bit0 (host, ref/2) from bit0, bit1 (memory reference, ref/4) from bit1, bit2 (66 MHz group, ref/4) from bit1, bit3 (PCI group, ref/8) from bit2, bit4 (48 MHz group, ref/2) from bit0.
- R9: `fsel_strap`=01 or 10 gives `mode_o`=5 (reserved), with `rsvd_flag`=1, `clk_oe`=1, `ref_pass`=0 and `grp_tclk`=0.
- R10: `imult_o` equals the multiplier minus 4. With `isel_strap[0]`=0 and `isel_strap[1]`=0 the multiplier is 5. With [0]=0 and [1]=1 it is 6. With [0]=1 and [1]=0 it is 4. With both 1 it is 7.
- R11: During reset and before capture, `mode_o`=0, `imult_o`=0, `clk_oe`=0, `ref_pass`=0, `rsvd_flag`=0 and `grp_tclk`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| por_n | input | 1 | Supply power-on reset, active low, asynchronous |
| pwr_dn_n | input | 1 | Power-down request, active low, asynchronous |
| fsel_strap | input | 2 | Frequency-select levels on the shared pins |
| isel_strap | input | 2 | Current-select levels on the shared pins |
| fhi_pin | input | 1 | High/low host frequency selector |
| mode_o | output | 3 | Decoded operating mode |
| imult_o | output | 2 | Host current multiplier code |
| strap_oe | output | 1 | Turns the shared pins into output drivers |
| clk_oe | output | 1 | Output enable for all clock groups |
| ref_pass | output | 1 | Route the reference clock to the reference outputs |
| grp_tclk | output | 5 | Test-mode divided clocks per group |
| rsvd_flag | output | 1 | Reserved strap code was captured |

## Verification
Two events can meet in adjacent cycles: the capture edge, and the shared pins changing level as they stop being inputs. The bench sweeps all 32 combinations of the five captured levels. In each run it inverts every strap and the selector on the cycle right after the capture edge, before the driver enable rises. It then judges `mode_o` and `imult_o` against values computed from the original levels. A second overlap, power-down during test mode with the strap levels changed again, is judged by the divided clocks going low and the mode surviving the exit.

// File: rtl/clkstrap_pkg.sv
package clkstrap_pkg;
  typedef enum logic [2:0] {
    MD_IDLE = 3'd0,
    MD_H100 = 3'd1,
    MD_H133 = 3'd2,
    MD_TEST = 3'd3,
    MD_TRI  = 3'd4,
    MD_RSVD = 3'd5
  } mode_e;

  localparam int unsigned NGRP = 5;
  localparam int unsigned DIVW = 3;
  // counter bit feeding each group: host, mref, 66, pci, 48
  localparam int unsigned GRP_TAP [NGRP] = '{0, 1, 1, 2, 0};
endpackage

// File: rtl/csg_rst_sync.sv
module csg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/csg_strap_capture.sv
module csg_strap_capture #(
  parameter int unsigned HOLD_CYC = 8,
  parameter int unsigned NF = 2,
  parameter int unsigned NI = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] fsel_in,
  input  logic [NI-1:0] isel_in,
  input  logic          fhi_in,
  output logic          lat_o,
  output logic          oe_o,
  output logic [NF-1:0] fsel_o,
  output logic [NI-1:0] isel_o,
  output logic          fhi_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lat_q, lat_d, oe_q, oe_d, cap_en;
  logic [NF-1:0] fsel_q;
  logic [NI-1:0] isel_q;
  logic          fhi_q;

  always_comb begin
    cap_en = !lat_q && (cnt_q == CW'(HOLD_CYC - 1));
    cnt_d  = cnt_q;
    if (!lat_q && !cap_en) cnt_d = cnt_q + CW'(1);
    lat_d  = lat_q | cap_en;
    oe_d   = lat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lat_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lat_q <= lat_d;
      oe_q  <= oe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsel_q <= '0;
      isel_q <= '0;
      fhi_q  <= 1'b0;
    end else if (cap_en) begin
      fsel_q <= fsel_in;
      isel_q <= isel_in;
      fhi_q  <= fhi_in;
    end
  end

  assign lat_o  = lat_q;
  assign oe_o   = oe_q;
  assign fsel_o = fsel_q;
  assign isel_o = isel_q;
  assign fhi_o  = fhi_q;

  // R2
  oe_follows_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lat_q) |=> oe_q);
  // R2
  oe_needs_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> lat_q);
  // R3
  held_straps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && $past(lat_q)) |-> ($stable(fsel_q) && $stable(isel_q) && $stable(fhi_q)));
endmodule

// File: rtl/csg_mode_decode.sv
module csg_mode_decode
  import clkstrap_pkg::*;
(
  input  logic       lat,
  input  logic [1:0] fsel,
  input  logic [1:0] isel,
  input  logic       fhi,
  output mode_e      mode,
  output logic [1:0] imult
);
  always_comb begin
    mode  = MD_IDLE;
    imult = 2'd0;
    if (lat) begin
      case (fsel)
        2'b00:   mode = fhi ? MD_H133 : MD_H100;
        2'b11:   mode = fhi ? MD_TEST : MD_TRI;
        default: mode = MD_RSVD;
      endcase
      case ({isel[1], isel[0]})
        2'b00:   imult = 2'd1;
        2'b10:   imult = 2'd2;
        2'b01:   imult = 2'd0;
        default: imult = 2'd3;
      endcase
    end
  end
endmodule

// File: rtl/csg_test_div.sv
module csg_test_div
  import clkstrap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  output logic [NGRP-1:0] tclk
);
  logic [DIVW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = en ? cnt_q + DIVW'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_tap
    assign tclk[g] = cnt_q[GRP_TAP[g]];
  end

  // R8
  div_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> (cnt_q == DIVW'($past(cnt_q) + DIVW'(1))));
endmodule

// File: rtl/strap_mode_ctrl.sv
module strap_mode_ctrl
  import clkstrap_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 8
) (
  input  logic            clk_ref,
  input  logic            por_n,
  input  logic            pwr_dn_n,
  input  logic [1:0]      fsel_strap,
  input  logic [1:0]      isel_strap,
  input  logic            fhi_pin,
  output logic [2:0]      mode_o,
  output logic [1:0]      imult_o,
  output logic            strap_oe,
  output logic            clk_oe,
  output logic            ref_pass,
  output logic [NGRP-1:0] grp_tclk,
  output logic            rsvd_flag
);
  logic            rst_n, lat, fhi_q;
  logic [1:0]      fsel_q, isel_q, run_q;
  logic            run, test_en;
  mode_e           mode;
  logic [NGRP-1:0] tclk_raw;

  csg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk_ref), .arst_n(por_n), .rst_n_o(rst_n));

  csg_strap_capture #(.HOLD_CYC(HOLD_CYC), .NF(2), .NI(2)) u_cap (
    .clk(clk_ref), .rst_n(rst_n), .fsel_in(fsel_strap), .isel_in(isel_strap),
    .fhi_in(fhi_pin), .lat_o(lat), .oe_o(strap_oe), .fsel_o(fsel_q),
    .isel_o(isel_q), .fhi_o(fhi_q));

  csg_mode_decode u_dec (
    .lat(lat), .fsel(fsel_q), .isel(isel_q), .fhi(fhi_q),
    .mode(mode), .imult(imult_o));

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) run_q <= 2'b00;
    else        run_q <= {run_q[0], pwr_dn_n};
  end
  assign run = run_q[1];

  assign test_en = run && (mode == MD_TEST);

  csg_test_div u_div (
    .clk(clk_ref), .rst_n(rst_n), .en(test_en), .tclk(tclk_raw));

  assign mode_o    = mode;
  assign grp_tclk  = test_en ? tclk_raw : '0;
  assign ref_pass  = run && (mode == MD_H100 || mode == MD_H133 || mode == MD_TEST);
  assign clk_oe    = (mode != MD_IDLE) && (mode != MD_TRI);
  assign rsvd_flag = (mode == MD_RSVD);

  // R7
  tri_quiet_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mode == MD_TRI) |-> (!clk_oe && grp_tclk == '0 && !ref_pass));
  // R9
  rsvd_low_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    rsvd_flag |-> (grp_tclk == '0 && !ref_pass && clk_oe));
  // R11
  idle_before_cap_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !strap_oe && (mode != MD_IDLE) |-> $rose(lat));
endmodule

// File: tb/sim_strap_mode_ctrl.sv
module sim_strap_mode_ctrl;
  localparam int HOLD = 8;

  logic       clk = 1'b0;
  logic       por_n, pwr_dn_n, fhi_pin;
  logic [1:0] fsel_strap, isel_strap;
  logic [2:0] mode_o;
  logic [1:0] imult_o;
  logic       strap_oe, clk_oe, ref_pass, rsvd_flag;
  logic [4:0] grp_tclk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  strap_mode_ctrl #(.HOLD_CYC(HOLD)) u0 (
    .clk_ref(clk), .por_n(por_n), .pwr_dn_n(pwr_dn_n), .fsel_strap(fsel_strap),
    .isel_strap(isel_strap), .fhi_pin(fhi_pin), .mode_o(mode_o), .imult_o(imult_o),
    .strap_oe(strap_oe), .clk_oe(clk_oe), .ref_pass(ref_pass),
    .grp_tclk(grp_tclk), .rsvd_flag(rsvd_flag));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_mode(input int fs, input int hi);
    if (fs == 0) return hi ? 2 : 1;
    if (fs == 3) return hi ? 3 : 4;
    return 5;
  endfunction

  function automatic int exp_imult(input int is);
    int i0 = is & 1;
    int i1 = (is >> 1) & 1;
    return 5 + i1 - i0 + 2 * i0 * i1 - 4;
  endfunction

  function automatic string mreq(input int m);
    case (m)
      1: return "R5";
      2: return "R6";
      3: return "R8";
      4: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic run_case(input int fs, input int is, input int hi);
    int em = exp_mode(fs, hi);
    int ei = exp_imult(is);
    string rq = mreq(em);
    int prev = 0;
    por_n = 1'b0;
    fsel_strap = 2'(fs);
    isel_strap = 2'(is);
    fhi_pin = 1'(hi);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(mode_o == 0 && imult_o == 0 && clk_oe == 0 && ref_pass == 0 &&
        rsvd_flag == 0 && grp_tclk == 0, "R11", "reset outputs", int'(mode_o), 0);
    chk(strap_oe == 0, "R2", "strap_oe in reset", int'(strap_oe), 0);
    por_n = 1'b1;
    for (int k = 1; k <= HOLD + 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == HOLD + 1) begin
        chk(mode_o == 0, "R1", "mode before capture", int'(mode_o), 0);
        chk(strap_oe == 0, "R2", "strap_oe before capture", int'(strap_oe), 0);
      end
      if (k == HOLD + 2) begin
        chk(int'(mode_o) == em, "R1", "mode at capture edge", int'(mode_o), em);
        chk(strap_oe == 0, "R2", "strap_oe at capture edge", int'(strap_oe), 0);
        fsel_strap = ~fsel_strap;
        isel_strap = ~isel_strap;
        fhi_pin = ~fhi_pin;
      end
      if (k == HOLD + 3) begin
        chk(strap_oe == 1, "R2", "strap_oe after capture", int'(strap_oe), 1);
      end
    end
    chk(int'(mode_o) == em, "R3", "mode after pin change", int'(mode_o), em);
    chk(int'(imult_o) == ei, "R10", "current code", int'(imult_o), ei);
    chk(int'(clk_oe) == ((em == 4) ? 0 : 1), rq, "clk_oe", int'(clk_oe), (em == 4) ? 0 : 1);
    chk(int'(ref_pass) == ((em <= 3) ? 1 : 0), rq, "ref_pass", int'(ref_pass), (em <= 3) ? 1 : 0);
    chk(int'(rsvd_flag) == ((em == 5) ? 1 : 0), rq, "rsvd_flag", int'(rsvd_flag), (em == 5) ? 1 : 0);
    for (int j = 0; j < 16; j++) begin
      @(negedge clk);
      if (em == 3) begin
        int v = {grp_tclk[3], grp_tclk[1], grp_tclk[0]};
        chk(grp_tclk[2] == grp_tclk[1] && grp_tclk[4] == grp_tclk[0], "R8",
            "group taps aligned", int'(grp_tclk), v);
        if (j > 0) chk(v == ((prev + 1) & 7), "R8", "divider phase", v, (prev + 1) & 7);
        prev = v;
      end else begin
        chk(grp_tclk == 0, rq, "test clocks idle", int'(grp_tclk), 0);
      end
    end
  endtask

  initial begin
    bit seen;
    por_n = 1'b0;
    pwr_dn_n = 1'b1;
    fsel_strap = 2'b00;
    isel_strap = 2'b00;
    fhi_pin = 1'b0;
    for (int fs = 0; fs < 4; fs++)
      for (int is = 0; is < 4; is++)
        for (int hi = 0; hi < 2; hi++)
          run_case(fs, is, hi);
    // R4: power-down in test mode, pins changed, no recapture on exit
    run_case(3, 2, 1);
    pwr_dn_n = 1'b0;
    fsel_strap = 2'b00;
    isel_strap = 2'b01;
    fhi_pin = 1'b0;
    repeat (4) @(negedge clk);
    chk(grp_tclk == 0 && ref_pass == 0, "R4", "outputs in power-down", int'(grp_tclk), 0);
    chk(mode_o == 3, "R4", "mode in power-down", int'(mode_o), 3);
    pwr_dn_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(mode_o == 3, "R4", "mode after power-down exit", int'(mode_o), 3);
    chk(int'(imult_o) == exp_imult(2), "R4", "code after exit", int'(imult_o), exp_imult(2));
    seen = 1'b0;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      if (grp_tclk != 0) seen = 1'b1;
    end
    chk(seen && ref_pass == 1, "R4", "test clocks resume", int'(seen), 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule